// File: doc/BRIEF.md
# SD Command Line Controller

This block drives the command line of an SD card bus from the host side. A write to the command inputs with the enable bit set launches one command. The block serializes a 48-bit frame onto the line and then, if the command asks for it, listens for the card's reply. Short replies are 48 bits and long replies are 136 bits. It checks the reply's CRC7, or ignores it for reply types that carry none, and records the result in sticky status flags that software clears one bit at a time.

All sequencing advances on a card-clock strobe, one bit per strobe period. Two special modes exist. In the card-interrupt mode the reply timeout is disabled and the block waits, without limit, for a card to pull the line low. In the held mode the frame is not sent until the data path raises a pend signal, which lets a stop command leave on an exact strobe. Once a command finishes, the line stays released for a fixed number of strobes before the next frame may begin.

Top module: `sd_cmd_engine`

## Requirements
- R1: A frame is launched only by a write (`cmd_wr_i`) with `cmd_en_i` high while the block is idle or in its release gap. A write with `cmd_en_i` low while idle, or any write while a frame is being sent, has no effect.
- R2: The frame is 48 bits, sent MSB first, one bit per strobe period: `0`, `1`, index[5:0], argument[31:0], CRC7 (polynomial x^7+x^3+1, register cleared to zero) over the first 40 bits, then `1`. `cmd_oe_o` is high only while the frame is on the line, and `cmd_o` is 1 whenever `cmd_oe_o` is low.
- R3: A command without a reply sets flag bit 0 (sent) when its last bit has been sent.
- R4: A command with a reply waits for the line to go low (start bit). It then takes 48 bits in total (short) or 136 bits in total (long). `rsp_o` holds the low 128 received bits, with bit 0 being the end bit and the unused upper bits zero for a short reply.
- R5: The reply CRC7 covers reply bits 47..8 (short) or 127..8 (long) and is compared with bits 7..1. A match sets flag bit 1 (reply ok) and a mismatch sets flag bit 2 (CRC fail). The two are never set by the same reply.
- R6: With `ign_crc_i` high, a CRC mismatch sets flag bit 1 and leaves flag bit 2 clear.
- R7: In reply mode, if the line stays high for 64 strobes after the frame, flag bit 3 (timeout) is set and no reply flag is set.
- R8: With `irq_wait_i` high there is no timeout. The first low level on the line ends the wait, sets flag bit 4 (card interrupt) and starts no reply reception.
- R9: With `pend_i` high, the frame is held with the line released until a strobe sees `data_pend_i` high. The first frame bit then appears on that strobe.
- R10: A write with `cmd_en_i` low while the command is held or waiting for a reply abandons it without setting any flag.
- R11: Every command end (including an abandon) is followed by at least 8 strobes with the line released. A command written during that gap starts on the first strobe after it, so between back-to-back frames `cmd_oe_o` is low for exactly 9 strobe periods.
- R12: Flags stay set until the matching bit of `clr_i` is pulsed; other bits are unaffected.
- R13: `busy_o` is high from an accepted write until the block is idle again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| ck_stb_i | input | 1 | Card-clock strobe, one cycle per card clock period |
| cmd_wr_i | input | 1 | Command register write pulse |
| cmd_en_i | input | 1 | Enable bit carried by the write |
| cmd_idx_i | input | 6 | Command index |
| cmd_arg_i | input | 32 | Command argument |
| rsp_req_i | input | 1 | Command expects a reply |
| rsp_long_i | input | 1 | Reply is 136 bits instead of 48 |
| ign_crc_i | input | 1 | Reply CRC is not checked |
| irq_wait_i | input | 1 | Wait for card interrupt, no timeout |
| pend_i | input | 1 | Hold the frame until the data path signals |
| data_pend_i | input | 1 | Release signal from the data path |
| clr_i | input | 5 | Write-1 clear pulses, one per flag |
| cmd_i | input | 1 | Command line level seen from the bus |
| cmd_o | output | 1 | Command line drive value |
| cmd_oe_o | output | 1 | Command line drive enable |
| busy_o | output | 1 | Command in progress |
| flags_o | output | 5 | Sticky flags: 0 sent, 1 reply ok, 2 CRC fail, 3 timeout, 4 card interrupt |
| rsp_o | output | 128 | Low 128 bits of the last reply |

## Verification
The hardest state to reach is a reply whose first bit lands on a precise strobe after the frame. A late start bit hits the timeout, and an early one is missed while the frame is still leaving. The bench watches the drive enable on every strobe and begins driving the reply a fixed two strobes after the captured end bit. It uses the same anchor to place the timeout check one strobe on each side of the 64-strobe limit. The held mode and the release gap are timed the same way, counting strobe periods between the data-path release or frame end and the next rise of the drive enable.

// File: rtl/sd_cmd_pkg.sv
package sd_cmd_pkg;
  localparam int unsigned IDX_W      = 6;
  localparam int unsigned ARG_W      = 32;
  localparam int unsigned HDR_W      = 2 + IDX_W + ARG_W;  // bits covered by the command CRC
  localparam int unsigned FRAME_BITS = HDR_W + 8;
  localparam int unsigned SHORT_BITS = 48;
  localparam int unsigned LONG_BITS  = 136;
  localparam int unsigned RSP_W      = 128;
  localparam int unsigned NFLAG      = 5;

  localparam int unsigned FLG_SENT = 0;
  localparam int unsigned FLG_OK   = 1;
  localparam int unsigned FLG_FAIL = 2;
  localparam int unsigned FLG_TMO  = 3;
  localparam int unsigned FLG_IRQ  = 4;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_PEND,
    ST_SEND,
    ST_WAIT,
    ST_RECV,
    ST_GAP
  } cmd_state_e;

  function automatic logic [6:0] crc7_step(input logic [6:0] crc, input logic din);
    logic fb;
    fb = crc[6] ^ din;
    crc7_step = {crc[5:0], 1'b0} ^ (fb ? 7'h09 : 7'h00);
  endfunction
endpackage

// File: rtl/sd_crc7.sv
module sd_crc7 import sd_cmd_pkg::*; (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       clr_i,
  input  logic       en_i,
  input  logic       bit_i,
  output logic [6:0] crc_o
);
  logic [6:0] crc_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)            crc_q <= '0;
    else if (clr_i && en_i) crc_q <= crc7_step(7'h00, bit_i);
    else if (clr_i)         crc_q <= '0;
    else if (en_i)          crc_q <= crc7_step(crc_q, bit_i);
  end

  assign crc_o = crc_q;
endmodule

// File: rtl/sd_cmd_tx.sv
module sd_cmd_tx import sd_cmd_pkg::*; (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             stb_i,
  input  logic             load_i,
  input  logic             run_i,
  input  logic [HDR_W-1:0] hdr_i,
  output logic             bit_o,
  output logic             last_o
);
  localparam int unsigned CNT_W = $clog2(FRAME_BITS);
  localparam logic [CNT_W-1:0] HDR_END = CNT_W'(HDR_W);
  localparam logic [CNT_W-1:0] CRC_END = CNT_W'(FRAME_BITS - 1);

  logic [HDR_W-1:0] sh_q;
  logic [CNT_W-1:0] cnt_q;
  logic             in_hdr, in_crc;
  logic [6:0]       crc_q;

  assign in_hdr = cnt_q < HDR_END;
  assign in_crc = !in_hdr && (cnt_q < CRC_END);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sh_q  <= '0;
      cnt_q <= '0;
      crc_q <= '0;
    end else if (load_i) begin
      sh_q  <= hdr_i;
      cnt_q <= '0;
      crc_q <= '0;
    end else if (stb_i && run_i) begin
      // CRC accumulates on the header, then shifts out behind it
      if (in_hdr) begin
        crc_q <= crc7_step(crc_q, sh_q[HDR_W-1]);
        sh_q  <= {sh_q[HDR_W-2:0], 1'b0};
      end else if (in_crc) begin
        crc_q <= {crc_q[5:0], 1'b0};
      end
      if (cnt_q != CRC_END) cnt_q <= cnt_q + 1'b1;
    end
  end

  assign bit_o  = in_hdr ? sh_q[HDR_W-1] : (in_crc ? crc_q[6] : 1'b1);
  assign last_o = stb_i && run_i && (cnt_q == CRC_END);
endmodule

// File: rtl/sd_cmd_rx.sv
module sd_cmd_rx import sd_cmd_pkg::*; (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             stb_i,
  input  logic             start_i,
  input  logic             active_i,
  input  logic             long_i,
  input  logic             bit_i,
  output logic             done_o,
  output logic             match_o,
  output logic [RSP_W-1:0] rsp_o
);
  localparam int unsigned CNT_W = $clog2(LONG_BITS + 1);
  localparam logic [CNT_W-1:0] N_SHORT = CNT_W'(SHORT_BITS);
  localparam logic [CNT_W-1:0] N_LONG  = CNT_W'(LONG_BITS);
  localparam logic [CNT_W-1:0] LONG_SKIP = CNT_W'(LONG_BITS - RSP_W);

  logic [CNT_W-1:0] cnt_q, k, n_bits, first_cov, last_cov;
  logic [RSP_W-1:0] sh_q;
  logic             cov, take;
  logic [6:0]       crc;

  assign n_bits    = long_i ? N_LONG : N_SHORT;
  assign first_cov = long_i ? LONG_SKIP : '0;
  assign last_cov  = n_bits - CNT_W'(9);
  assign k         = start_i ? '0 : cnt_q;
  assign cov       = (k >= first_cov) && (k <= last_cov);
  assign take      = stb_i && (start_i || active_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sh_q  <= '0;
      cnt_q <= '0;
    end else if (start_i) begin
      sh_q  <= {{(RSP_W-1){1'b0}}, bit_i};
      cnt_q <= CNT_W'(1);
    end else if (take) begin
      sh_q  <= {sh_q[RSP_W-2:0], bit_i};
      cnt_q <= cnt_q + 1'b1;
    end
  end

  sd_crc7 u_crc (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .clr_i  (start_i),
    .en_i   (take && cov),
    .bit_i  (bit_i),
    .crc_o  (crc)
  );

  assign done_o  = active_i && stb_i && (cnt_q == n_bits - CNT_W'(1));
  // sh_q[6:0] holds reply bits 7..1 while the end bit is on the line
  assign match_o = (crc == sh_q[6:0]);
  assign rsp_o   = sh_q;

  AST_RX_BOUND: assert property (@(posedge clk_i) disable iff (!rst_ni)
    active_i |-> (cnt_q < n_bits)); // R4
endmodule

// File: rtl/sd_cmd_engine.sv
module sd_cmd_engine import sd_cmd_pkg::*; #(
  parameter int unsigned TMO_STROBES = 64,
  parameter int unsigned GAP_STROBES = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             ck_stb_i,
  input  logic             cmd_wr_i,
  input  logic             cmd_en_i,
  input  logic [IDX_W-1:0] cmd_idx_i,
  input  logic [ARG_W-1:0] cmd_arg_i,
  input  logic             rsp_req_i,
  input  logic             rsp_long_i,
  input  logic             ign_crc_i,
  input  logic             irq_wait_i,
  input  logic             pend_i,
  input  logic             data_pend_i,
  input  logic [NFLAG-1:0] clr_i,
  input  logic             cmd_i,
  output logic             cmd_o,
  output logic             cmd_oe_o,
  output logic             busy_o,
  output logic [NFLAG-1:0] flags_o,
  output logic [RSP_W-1:0] rsp_o
);
  localparam int unsigned MAXC  = (TMO_STROBES > GAP_STROBES) ? TMO_STROBES : GAP_STROBES;
  localparam int unsigned CNT_W = (MAXC > 2) ? $clog2(MAXC) : 1;
  localparam logic [CNT_W-1:0] TMO_LAST = CNT_W'(TMO_STROBES - 1);
  localparam logic [CNT_W-1:0] GAP_LAST = CNT_W'(GAP_STROBES - 1);
  localparam int unsigned GS_W = $clog2(GAP_STROBES + 1);
  localparam logic [GS_W-1:0] GAP_SAT = GS_W'(GAP_STROBES);

  cmd_state_e       state_q, state_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic [IDX_W-1:0] idx_q;
  logic [ARG_W-1:0] arg_q;
  logic             rsp_q, long_q, ign_q, irq_q, pend_q, go_q;
  logic [NFLAG-1:0] flags_q, set_flags;
  logic             acc, abort, tx_load, tx_bit, tx_last, rx_start, rx_done, rx_match;

  assign acc   = cmd_wr_i && cmd_en_i && !go_q &&
                 ((state_q == ST_IDLE) || (state_q == ST_GAP));
  assign abort = cmd_wr_i && !cmd_en_i &&
                 ((state_q == ST_PEND) || (state_q == ST_WAIT));

  always_comb begin
    state_d   = state_q;
    cnt_d     = cnt_q;
    set_flags = '0;
    tx_load   = 1'b0;
    rx_start  = 1'b0;
    if (abort) begin
      state_d = ST_GAP;
      cnt_d   = '0;
    end else if (ck_stb_i) begin
      unique case (state_q)
        ST_IDLE: if (go_q) begin
          if (pend_q) state_d = ST_PEND;
          else begin
            state_d = ST_SEND;
            tx_load = 1'b1;
          end
        end
        ST_PEND: if (data_pend_i) begin
          state_d = ST_SEND;
          tx_load = 1'b1;
        end
        ST_SEND: if (tx_last) begin
          cnt_d = '0;
          if (rsp_q || irq_q) state_d = ST_WAIT;
          else begin
            state_d             = ST_GAP;
            set_flags[FLG_SENT] = 1'b1;
          end
        end
        ST_WAIT: begin
          if (!cmd_i) begin
            cnt_d = '0;
            if (irq_q) begin
              state_d            = ST_GAP;
              set_flags[FLG_IRQ] = 1'b1;
            end else begin
              state_d  = ST_RECV;
              rx_start = 1'b1;
            end
          end else if (!irq_q) begin
            if (cnt_q == TMO_LAST) begin
              state_d            = ST_GAP;
              cnt_d              = '0;
              set_flags[FLG_TMO] = 1'b1;
            end else begin
              cnt_d = cnt_q + 1'b1;
            end
          end
        end
        ST_RECV: if (rx_done) begin
          state_d = ST_GAP;
          cnt_d   = '0;
          if (rx_match || ign_q) set_flags[FLG_OK]   = 1'b1;
          else                   set_flags[FLG_FAIL] = 1'b1;
        end
        ST_GAP: begin
          if (cnt_q == GAP_LAST) state_d = ST_IDLE;
          else                   cnt_d   = cnt_q + 1'b1;
        end
        default: state_d = ST_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      cnt_q   <= '0;
      flags_q <= '0;
      go_q    <= 1'b0;
      idx_q   <= '0;
      arg_q   <= '0;
      rsp_q   <= 1'b0;
      long_q  <= 1'b0;
      ign_q   <= 1'b0;
      irq_q   <= 1'b0;
      pend_q  <= 1'b0;
    end else begin
      state_q <= state_d;
      cnt_q   <= cnt_d;
      flags_q <= (flags_q & ~clr_i) | set_flags;
      if (acc) begin
        go_q   <= 1'b1;
        idx_q  <= cmd_idx_i;
        arg_q  <= cmd_arg_i;
        rsp_q  <= rsp_req_i;
        long_q <= rsp_long_i;
        ign_q  <= ign_crc_i;
        irq_q  <= irq_wait_i;
        pend_q <= pend_i;
      end else if (ck_stb_i && (state_q == ST_IDLE)) begin
        go_q <= 1'b0;
      end
    end
  end

  sd_cmd_tx u_tx (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .stb_i  (ck_stb_i),
    .load_i (tx_load),
    .run_i  (state_q == ST_SEND),
    .hdr_i  ({2'b01, idx_q, arg_q}),
    .bit_o  (tx_bit),
    .last_o (tx_last)
  );

  sd_cmd_rx u_rx (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .stb_i    (ck_stb_i),
    .start_i  (rx_start),
    .active_i (state_q == ST_RECV),
    .long_i   (long_q),
    .bit_i    (cmd_i),
    .done_o   (rx_done),
    .match_o  (rx_match),
    .rsp_o    (rsp_o)
  );

  assign cmd_oe_o = (state_q == ST_SEND);
  assign cmd_o    = cmd_oe_o ? tx_bit : 1'b1;
  assign busy_o   = go_q || (state_q != ST_IDLE);
  assign flags_o  = flags_q;

  // strobes seen with the line released since the last driven cycle
  logic [GS_W-1:0] gap_seen_q;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                               gap_seen_q <= GAP_SAT;
    else if (cmd_oe_o)                         gap_seen_q <= '0;
    else if (ck_stb_i && gap_seen_q < GAP_SAT) gap_seen_q <= gap_seen_q + 1'b1;
  end

  AST_START_LOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(cmd_oe_o) |-> !cmd_o); // R2
  AST_GAP_KEPT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(cmd_oe_o) |-> (gap_seen_q >= GAP_SAT)); // R11
  AST_FLAGS_STICKY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (clr_i == '0) |=> ((flags_o & $past(flags_o)) == $past(flags_o))); // R12
  AST_CRC_EXCL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !($rose(flags_o[FLG_OK]) && $rose(flags_o[FLG_FAIL]))); // R5
  AST_IRQ_NO_TMO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((state_q == ST_WAIT) && irq_q) |=> !$rose(flags_o[FLG_TMO])); // R8
endmodule

// File: tb/sd_cmd_engine_tb.sv
module sd_cmd_engine_tb;
  localparam int CLK_PERIOD = 10;

  logic         clk = 0, rst_ni = 0, stb = 0;
  logic         cmd_wr = 0, cmd_en = 0, rsp_req = 0, rsp_long = 0, ign_crc = 0;
  logic         irq_wait = 0, pend = 0, data_pend = 0, cmd_i = 1;
  logic [5:0]   cmd_idx = 0;
  logic [31:0]  cmd_arg = 0;
  logic [4:0]   clr = 0;
  logic         cmd_o, cmd_oe, busy;
  logic [4:0]   flags;
  logic [127:0] rsp;

  int checks = 0, errors = 0;
  int stb_div = 1, sc = 0;
  logic [135:0] cap = '0;
  int cap_cnt = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  sd_cmd_engine u_dut (
    .clk_i(clk), .rst_ni(rst_ni), .ck_stb_i(stb), .cmd_wr_i(cmd_wr), .cmd_en_i(cmd_en),
    .cmd_idx_i(cmd_idx), .cmd_arg_i(cmd_arg), .rsp_req_i(rsp_req), .rsp_long_i(rsp_long),
    .ign_crc_i(ign_crc), .irq_wait_i(irq_wait), .pend_i(pend), .data_pend_i(data_pend),
    .clr_i(clr), .cmd_i(cmd_i), .cmd_o(cmd_o), .cmd_oe_o(cmd_oe), .busy_o(busy),
    .flags_o(flags), .rsp_o(rsp)
  );

  always @(negedge clk) begin
    if (sc >= stb_div - 1) begin sc = 0; stb = 1; end
    else begin sc = sc + 1; stb = 0; end
  end

  always begin
    @(negedge clk);
    #1;
    if (stb && cmd_oe) begin
      cap = {cap[134:0], cmd_o};
      cap_cnt = cap_cnt + 1;
    end
  end

  task automatic tick(input int n);
    repeat (n) begin @(negedge clk); #2; end
  endtask

  task automatic chk(input bit ok, input string req, input logic [135:0] act, input logic [135:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [6:0] crc7(input logic [135:0] v, input int hi, input int lo);
    logic [6:0] c = 0;
    for (int i = hi; i >= lo; i--) begin
      logic fb = c[6] ^ v[i];
      c = {c[5:0], 1'b0};
      if (fb) c = c ^ 7'h09;
    end
    return c;
  endfunction

  function automatic logic [47:0] mk_cmd(input logic [5:0] idx, input logic [31:0] arg);
    logic [39:0] h = {2'b01, idx, arg};
    return {h, crc7({96'b0, h}, 39, 0), 1'b1};
  endfunction

  function automatic logic [47:0] mk_short(input logic [5:0] idx, input logic [31:0] arg, input bit bad);
    logic [39:0] h = {2'b00, idx, arg};
    logic [6:0] c = crc7({96'b0, h}, 39, 0);
    if (bad) c = c ^ 7'h01;
    return {h, c, 1'b1};
  endfunction

  function automatic logic [135:0] mk_long(input bit bad);
    logic [119:0] body = {32'hA5A5_0F0F, 32'h1234_5678, 32'hDEAD_BEEF, 24'hC0FFEE};
    logic [6:0] c = crc7({16'b0, body}, 119, 0);
    if (bad) c = c ^ 7'h10;
    return {8'h3F, body, c, 1'b1};
  endfunction

  task automatic issue(input logic [5:0] idx, input logic [31:0] arg, input bit en, input bit rq,
                       input bit lg, input bit ig, input bit iq, input bit pd);
    cmd_idx = idx; cmd_arg = arg; cmd_en = en; rsp_req = rq; rsp_long = lg;
    ign_crc = ig; irq_wait = iq; pend = pd; cmd_wr = 1;
    tick(1);
    cmd_wr = 0;
  endtask

  task automatic wait_frame();
    int g = 0;
    while (cap_cnt < 48 && g < 3000) begin tick(1); g++; end
  endtask

  task automatic wait_idle();
    int g = 0;
    while (busy && g < 3000) begin tick(1); g++; end
  endtask

  task automatic send_rsp(input logic [135:0] r, input int n);
    cmd_i = 1;
    tick(2);
    for (int i = n - 1; i >= 0; i--) begin cmd_i = r[i]; tick(1); end
    cmd_i = 1;
  endtask

  task automatic clear_all();
    clr = 5'h1F; tick(1); clr = 0;
  endtask

  task automatic t_reset();
    chk(flags == 0, "R12 reset flags", flags, 0);
    chk(!cmd_oe && cmd_o, "R2 reset line released", {cmd_oe, cmd_o}, 2'b01);
    chk(!busy, "R13 reset idle", busy, 0);
  endtask

  task automatic t_no_rsp_slow();
    stb_div = 3;
    cap_cnt = 0;
    issue(6'h11, 32'hCAFE_1234, 1, 0, 0, 0, 0, 0);
    chk(busy, "R13 busy after write", busy, 1);
    wait_frame();
    chk(cap[47:0] == mk_cmd(6'h11, 32'hCAFE_1234), "R2 frame slow strobe", cap[47:0], mk_cmd(6'h11, 32'hCAFE_1234));
    wait_idle();
    chk(flags == 5'b00001, "R3 sent flag", flags, 5'b00001);
    stb_div = 1;
    tick(3);
    clear_all();
  endtask

  task automatic t_ignored_writes();
    cap_cnt = 0;
    issue(6'h05, 32'h1, 0, 0, 0, 0, 0, 0);
    tick(20);
    chk(cap_cnt == 0 && !busy, "R1 disabled write ignored", cap_cnt, 0);
    issue(6'h0C, 32'h0000_00AA, 1, 0, 0, 0, 0, 0);
    tick(10);
    issue(6'h2A, 32'hFFFF_0000, 1, 0, 0, 0, 0, 0);
    wait_frame();
    chk(cap[47:0] == mk_cmd(6'h0C, 32'hAA), "R1 write during send ignored", cap[47:0], mk_cmd(6'h0C, 32'hAA));
    wait_idle();
    tick(20);
    chk(cap_cnt == 48, "R1 no second frame", cap_cnt, 48);
    clear_all();
  endtask

  task automatic t_gap();
    int low;
    cap_cnt = 0;
    issue(6'h07, 32'h0, 1, 0, 0, 0, 0, 0);
    wait_frame();
    cap_cnt = 0;
    tick(1);
    low = 1;
    issue(6'h0D, 32'h8765_4321, 1, 0, 0, 0, 0, 0);
    if (!cmd_oe) low++;
    while (!cmd_oe && low < 60) begin tick(1); if (!cmd_oe) low++; end
    chk(low == 9, "R11 release gap length", low, 9);
    wait_frame();
    chk(cap[47:0] == mk_cmd(6'h0D, 32'h8765_4321), "R11 queued command sent", cap[47:0], mk_cmd(6'h0D, 32'h8765_4321));
    wait_idle();
    clear_all();
  endtask

  task automatic t_short(input bit bad, input bit ig);
    logic [47:0] r = mk_short(6'h03, 32'h5A5A_0001, bad);
    cap_cnt = 0;
    issue(6'h03, 32'h0, 1, 1, 0, ig, 0, 0);
    wait_frame();
    send_rsp({88'b0, r}, 48);
    wait_idle();
    if (!bad)
      chk(flags == 5'b00010, "R5 short CRC ok", flags, 5'b00010);
    else if (ig)
      chk(flags == 5'b00010, "R6 ignored CRC", flags, 5'b00010);
    else
      chk(flags == 5'b00100, "R5 short CRC fail", flags, 5'b00100);
    chk(rsp == {80'b0, r}, "R4 short reply captured", rsp, {80'b0, r});
    clear_all();
  endtask

  task automatic t_long(input bit bad);
    logic [135:0] r = mk_long(bad);
    cap_cnt = 0;
    issue(6'h02, 32'h0, 1, 1, 1, 0, 0, 0);
    wait_frame();
    send_rsp(r, 136);
    wait_idle();
    chk(flags == (bad ? 5'b00100 : 5'b00010), "R5 long CRC", flags, bad ? 5'b00100 : 5'b00010);
    chk(rsp == r[127:0], "R4 long reply captured", rsp, r[127:0]);
    clear_all();
  endtask

  task automatic t_timeout();
    cap_cnt = 0;
    cmd_i = 1;
    issue(6'h08, 32'h1AA, 1, 1, 0, 0, 0, 0);
    wait_frame();
    tick(64);
    chk(flags[3] == 0, "R7 no timeout at 63", flags, 0);
    tick(1);
    chk(flags == 5'b01000, "R7 timeout at 64", flags, 5'b01000);
    wait_idle();
  endtask

  task automatic t_partial_clear();
    cap_cnt = 0;
    issue(6'h00, 32'h0, 1, 0, 0, 0, 0, 0);
    wait_frame();
    wait_idle();
    chk(flags == 5'b01001, "R12 flags accumulate", flags, 5'b01001);
    clr = 5'b00001; tick(1); clr = 0;
    chk(flags == 5'b01000, "R12 single bit clear", flags, 5'b01000);
    tick(5);
    chk(flags == 5'b01000, "R12 flag held", flags, 5'b01000);
    clear_all();
  endtask

  task automatic t_irq();
    cap_cnt = 0;
    issue(6'h34, 32'h0, 1, 1, 0, 0, 1, 0);
    wait_frame();
    tick(200);
    chk(flags == 0 && busy && !cmd_oe, "R8 no timeout in irq wait", {flags, busy, cmd_oe}, 7'b0000010);
    cmd_i = 0; tick(1); cmd_i = 1;
    chk(flags == 5'b10000, "R8 card interrupt flag", flags, 5'b10000);
    wait_idle();
    clear_all();
  endtask

  task automatic t_pend();
    bit early = 0;
    cap_cnt = 0;
    issue(6'h0C, 32'h0, 1, 0, 0, 0, 0, 1);
    for (int i = 0; i < 20; i++) begin tick(1); if (cmd_oe) early = 1; end
    chk(!early && busy, "R9 held while pending", {early, busy}, 2'b01);
    data_pend = 1; tick(1); data_pend = 0;
    chk(cmd_oe && !cmd_o, "R9 start bit on release strobe", {cmd_oe, cmd_o}, 2'b10);
    wait_frame();
    chk(cap[47:0] == mk_cmd(6'h0C, 32'h0), "R9 held frame", cap[47:0], mk_cmd(6'h0C, 32'h0));
    wait_idle();
    clear_all();
  endtask

  task automatic t_abort();
    bit drove = 0;
    cap_cnt = 0;
    issue(6'h0C, 32'h0, 1, 0, 0, 0, 0, 1);
    tick(5);
    issue(6'h0, 32'h0, 0, 0, 0, 0, 0, 0);
    data_pend = 1;
    for (int i = 0; i < 30; i++) begin tick(1); if (cmd_oe) drove = 1; end
    data_pend = 0;
    chk(!drove && !busy && flags == 0, "R10 abandon held command", {drove, busy, flags}, 0);
    cap_cnt = 0;
    issue(6'h01, 32'h0, 1, 1, 0, 0, 0, 0);
    wait_frame();
    tick(10);
    issue(6'h0, 32'h0, 0, 0, 0, 0, 0, 0);
    wait_idle();
    tick(80);
    chk(flags == 0, "R10 abandon reply wait", flags, 0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++; checks++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    tick(3);
    rst_ni = 1;
    tick(2);
    t_reset();
    t_no_rsp_slow();
    t_ignored_writes();
    t_gap();
    t_short(0, 0);
    t_short(1, 0);
    t_short(1, 1);
    t_long(0);
    t_long(1);
    t_timeout();
    t_partial_clear();
    t_irq();
    t_pend();
    t_abort();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule